// File: doc/BRIEF.md
# General-Purpose I/O Port with Read-Modify-Write Bit Engine

This block is a parameterised I/O port, eight pins wide by default. Each pin has a direction bit and an output data latch bit. A pin whose direction bit is 1 drives its latch bit onto the pad. A pin whose direction bit is 0 leaves the pad undriven. Its pad level passes through a multi-flop synchroniser before any logic uses it.

A simple request bus controls the port. Bus writes load the direction register and the data latch. Bus reads return either the direction register or a mixed port view: the live synchronised level for input pins and the latch for output pins.

Two command addresses start a single-bit set or clear, carried out by a small sequencer. The sequencer reads the mixed port view, changes one bit of it, and writes the whole byte back into the latch. As a result, the latch bits of every input pin take the level seen on their pads. This is intended: the block reproduces that behaviour exactly, so that software written around it sees the same effects. While the sequencer runs, `busy` is high and the bus is stalled with `req_ready` low.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset the direction register and the data latch are both 0x00. `pad_oe` and `pad_out` read 0x00, `busy` is 0 and `req_ready` is 1.
- R2: A write to address 0 loads the direction register. `pad_oe[i]` equals direction bit i, where 1 means output and 0 means input. A read of address 0 returns the direction register.
- R3: `pad_out` always equals the data latch, so an output pin drives its latch bit onto its pad.
- R4: A write to address 1 stores all bits into the data latch whatever the direction. An input pin holds its stored bit without driving it, and shows that bit once it is switched to output.
- R5: A read of address 1 returns, for each bit, the synchronised pad level if the bit is an input and the latch bit if it is an output. A read of address 2 or 3 returns 0.
- R6: A change on `pad_in` reaches the port read value only after two rising clock edges. A read accepted on the first edge after the change still returns the old level.
- R7: A write to address 2 starts a bit-set. The sequencer reads the mixed port view (as in R5), forces the addressed bit to 1, and writes the full byte into the latch. Example: direction 0x3F, latch 0x80, pin 7 low and pin 6 high; a set of bit 0 leaves the latch at 0x41.
- R8: A write to address 3 starts a bit-clear. It runs the same sequence as R7, forcing the addressed bit to 0.
- R9: After a bit command is accepted, `busy` stays high for exactly three cycles. During that time `req_ready` is low and no other request takes effect until `busy` falls.
- R10: The bit number of a command is taken from the low log2(WIDTH) bits of `req_wdata`, and higher bits are ignored. With WIDTH 8, a data value of 0x0B addresses bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write or command, 0 = read |
| req_addr | input | 2 | 0 direction, 1 data/port, 2 bit-set, 3 bit-clear |
| req_wdata | input | WIDTH | Write data or bit number |
| req_ready | output | 1 | Request accepted on this edge when high |
| rd_valid | output | 1 | Read data valid, one cycle after acceptance |
| rd_data | output | WIDTH | Read data |
| pad_in | input | WIDTH | Asynchronous pad levels |
| pad_out | output | WIDTH | Pad drive values (the latch) |
| pad_oe | output | WIDTH | Pad output enables (the direction register) |
| busy | output | 1 | Bit sequencer active |

## Verification
The bit sequencer is driven with a range of direction masks: all outputs, all inputs, split nibbles and a single output at each end. The latch contents differ from the pad levels on the input pins, so a correct read-back can be told apart from one that uses the latch everywhere or the pins everywhere. The all-output case shows that nothing is disturbed when no pin is an input. The mixed cases show that input-pin latch bits are overwritten by pad levels. Set and clear cases, together with a bit number carrying stray high bits, separate the polarity of the operation and the index decode.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADR_DIR  = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_DATA = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_BSET = 2'd2;
   localparam logic [ADDR_W-1:0] ADR_BCLR = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_MODIFY,
      ST_WRITE
   } bitop_state_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_in_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int           W       = 8,
   parameter logic [W-1:0] DIR_RST = '0,
   parameter logic [W-1:0] LAT_RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dir_we,
   input  logic [W-1:0] dir_wd,
   input  logic         bus_lat_we,
   input  logic [W-1:0] bus_lat_wd,
   input  logic         eng_lat_we,
   input  logic [W-1:0] eng_lat_wd,
   input  logic [W-1:0] pin_sync,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] lat_q,
   output logic [W-1:0] port_view
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= DIR_RST;
      else if (dir_we) dir_q <= dir_wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lat_q <= LAT_RST;
      else if (eng_lat_we) lat_q <= eng_lat_wd;
      else if (bus_lat_we) lat_q <= bus_lat_wd;
   end

   // per-pin view: output pins show the latch, input pins the pad
   for (genvar b = 0; b < W; b++) begin : g_view
      assign port_view[b] = dir_q[b] ? lat_q[b] : pin_sync[b];
   end

   // R4
   lat_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_lat_we && bus_lat_we));

   // R2
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_we |=> $stable(dir_q));

endmodule

// File: rtl/gpio_bitop_engine.sv
module gpio_bitop_engine
   import gpio_rmw_pkg::*;
#(
   parameter int W     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_set,
   input  logic [IDX_W-1:0] start_idx,
   input  logic [W-1:0]     port_view,
   output logic             busy,
   output logic             lat_we,
   output logic [W-1:0]     lat_wd,
   output logic [IDX_W-1:0] cur_idx,
   output logic             cur_set
);

   bitop_state_e state_q;
   logic [W-1:0] snap_q;
   logic [W-1:0] res_q;
   logic [W-1:0] modified;

   for (genvar b = 0; b < W; b++) begin : g_mod
      assign modified[b] = (cur_idx == IDX_W'(b)) ? cur_set : snap_q[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         snap_q  <= '0;
         res_q   <= '0;
         cur_idx <= '0;
         cur_set <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               cur_idx <= start_idx;
               cur_set <= start_set;
               state_q <= ST_READ;
            end
            ST_READ: begin
               snap_q  <= port_view;
               state_q <= ST_MODIFY;
            end
            ST_MODIFY: begin
               res_q   <= modified;
               state_q <= ST_WRITE;
            end
            ST_WRITE: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state_q != ST_IDLE);
   assign lat_we = (state_q == ST_WRITE);
   assign lat_wd = res_q;

   // R9
   start_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

   // R9
   seq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ) |=> (state_q == ST_MODIFY));

   // R9
   seq_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_MODIFY) |=> (state_q == ST_WRITE));

   // R9
   seq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE) |=> !busy);

   // R7
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ) |=> (snap_q == $past(port_view)));

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
   import gpio_rmw_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WIDTH-1:0]  req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [WIDTH-1:0]  rd_data,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   output logic              busy
);

   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   if ((1 << IDX_W) != WIDTH) begin : g_bad_width
      $error("gpio_rmw_port: WIDTH must be a power of two, at least 2");
   end

   logic             accept, wr_acc, rd_acc;
   logic             dir_we, bus_lat_we, start, start_set;
   logic [WIDTH-1:0] pin_sync, dir_q, lat_q, port_view;
   logic             eng_we, cur_set;
   logic [WIDTH-1:0] eng_wd;
   logic [IDX_W-1:0] cur_idx;
   logic [WIDTH-1:0] rd_mux;

   assign req_ready  = !busy;
   assign accept     = req_valid && req_ready;
   assign wr_acc     = accept && req_write;
   assign rd_acc     = accept && !req_write;
   assign dir_we     = wr_acc && (req_addr == ADR_DIR);
   assign bus_lat_we = wr_acc && (req_addr == ADR_DATA);
   assign start      = wr_acc && ((req_addr == ADR_BSET) || (req_addr == ADR_BCLR));
   assign start_set  = (req_addr == ADR_BSET);

   gpio_in_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_sync)
   );

   gpio_port_regs #(.W(WIDTH)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .dir_we     (dir_we),
      .dir_wd     (req_wdata),
      .bus_lat_we (bus_lat_we),
      .bus_lat_wd (req_wdata),
      .eng_lat_we (eng_we),
      .eng_lat_wd (eng_wd),
      .pin_sync   (pin_sync),
      .dir_q      (dir_q),
      .lat_q      (lat_q),
      .port_view  (port_view)
   );

   gpio_bitop_engine #(.W(WIDTH), .IDX_W(IDX_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_set (start_set),
      .start_idx (req_wdata[IDX_W-1:0]),
      .port_view (port_view),
      .busy      (busy),
      .lat_we    (eng_we),
      .lat_wd    (eng_wd),
      .cur_idx   (cur_idx),
      .cur_set   (cur_set)
   );

   always_comb begin
      unique case (req_addr)
         ADR_DIR:  rd_mux = dir_q;
         ADR_DATA: rd_mux = port_view;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_acc;
         if (rd_acc) rd_data <= rd_mux;
      end
   end

   assign pad_out = lat_q;
   assign pad_oe  = dir_q;

   // R9
   cmd_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R2
   oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_we |=> $stable(pad_oe));

   // R7
   bitop_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |=> (pad_out[cur_idx] == cur_set));

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_we && !bus_lat_we) |=> $stable(pad_out));

endmodule

// File: tb/tb_gpio_rmw_port.sv
`timescale 1ns/1ps
module tb_gpio_rmw_port;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic [1:0]   req_addr = '0;
   logic [W-1:0] req_wdata = '0;
   logic         req_ready, rd_valid, busy;
   logic [W-1:0] rd_data, pad_out, pad_oe;
   logic [W-1:0] pad_in = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_rmw_port #(.WIDTH(W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .rd_valid(rd_valid),
      .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .busy(busy)
   );

   // {dir, latch, pins, op(1 set / 0 clear), cmd data, expected latch}
   localparam logic [47:0] VECS [0:6] = '{
      {8'h3F, 8'h80, 8'h40, 8'h01, 8'h00, 8'h41},  // R7 mixed example
      {8'hFF, 8'h80, 8'h00, 8'h01, 8'h00, 8'h81},  // R7 all outputs
      {8'h00, 8'hAA, 8'h55, 8'h01, 8'h01, 8'h57},  // R7 all inputs
      {8'hF0, 8'h0F, 8'h3C, 8'h00, 8'h04, 8'h0C},  // R8 split nibbles
      {8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h0E},  // R8 low outputs
      {8'h81, 8'h00, 8'hFF, 8'h01, 8'h07, 8'hFE},  // R7 top bit
      {8'hFF, 8'h00, 8'h00, 8'h01, 8'h0B, 8'h08}   // R10 stray high bits
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      d = rd_valid ? rd_data : 'x;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [W-1:0] rv;
      int stall;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pad_oe", pad_oe, 8'h00);
      chk("R1 pad_out", pad_out, 8'h00);
      chk("R1 busy/ready", {6'd0, busy, req_ready}, 8'h01);
      bus_read(2'd0, rv);
      chk("R2 dir read after reset", rv, 8'h00);

      // vector table walk: R7 R8 R10 with R3 R5 cross-checks
      foreach (VECS[i]) begin
         logic [W-1:0] vd, vl, vp, vo, vc, ve;
         {vd, vl, vp, vo, vc, ve} = VECS[i];
         bus_write(2'd0, vd);
         bus_write(2'd1, vl);
         pad_in = vp;
         repeat (4) @(negedge clk);
         bus_write(vo[0] ? 2'd2 : 2'd3, vc);
         wait_idle();
         chk(vo[0] ? "R7 bit-set latch" : "R8 bit-clear latch", pad_out, ve);
         chk("R2 pad_oe", pad_oe, vd);
         bus_read(2'd1, rv);
         chk("R5 port read", rv, (vd & ve) | (~vd & vp));
      end

      // R4 latch write while inputs, not driven, shows after switch
      bus_write(2'd0, 8'h00);
      pad_in = 8'h00;
      bus_write(2'd1, 8'hC3);
      chk("R4 oe stays off", pad_oe, 8'h00);
      chk("R3 pad_out follows latch", pad_out, 8'hC3);
      repeat (3) @(negedge clk);
      bus_read(2'd1, rv);
      chk("R5 inputs read pins", rv, 8'h00);
      bus_write(2'd0, 8'hFF);
      bus_read(2'd1, rv);
      chk("R4 stored bits visible", rv, 8'hC3);

      // R5 command addresses read zero
      bus_read(2'd2, rv);
      chk("R5 addr2 read", rv, 8'h00);
      bus_read(2'd3, rv);
      chk("R5 addr3 read", rv, 8'h00);

      // R6 synchroniser latency
      bus_write(2'd0, 8'h00);
      pad_in = 8'h00;
      repeat (4) @(negedge clk);
      pad_in = 8'hFF;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R6 read one edge after change", rd_data, 8'h00);
      repeat (3) @(negedge clk);
      bus_read(2'd1, rv);
      chk("R6 read after settle", rv, 8'hFF);

      // R9 busy length and stall of a following request
      pad_in = 8'h00;
      bus_write(2'd1, 8'h00);
      repeat (3) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd2; req_wdata = 8'h02;
      @(posedge clk);
      @(negedge clk);
      req_addr = 2'd0; req_wdata = 8'hFF;
      stall = 0;
      while (!req_ready && stall < 20) begin
         stall++;
         if (pad_oe !== 8'h00) chk("R9 dir write held off", pad_oe, 8'h00);
         @(negedge clk);
      end
      chk("R9 busy cycles", 8'(stall), 8'd3);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk("R9 stalled write lands", pad_oe, 8'hFF);
      chk("R7 set bit2 all inputs", pad_out, 8'h04);

      // R1 reset again mid-state
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset clears dir", pad_oe, 8'h00);
      chk("R1 reset clears latch", pad_out, 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule